// File: doc/BRIEF.md
# Condition Flag Generator and Branch Condition Evaluator

This combinational unit forms the four status flags (negative, zero, overflow, carry) for one result, together with an eight-bit field of per-nibble decimal carries. It computes the result itself in one of four modes, chosen by a two-bit mode input. The add mode sums the first operand with the second operand shifted left. The right-shift mode shifts the first operand arithmetically. The test mode passes the first operand through and flags any zero byte. The left-shift mode shifts the first operand left and flags any loss of its significant bits.

A second, independent path takes a four-bit condition selector and the flags held in the surrounding status register. It returns one bit that says whether the branch condition holds. Storage of the flags, instruction decode and the wider arithmetic unit lie outside this block. The caller writes the flag outputs back to its own status register and feeds the stored copy to the flag inputs.

Top module: `flag_unit`

## Requirements
- R1: Mode encoding is 0 add, 1 arithmetic right shift, 2 test, 3 left shift. In add mode the result is opX + (opY << shiftAmt), truncated to 32 bits.
- R2: In add mode the carry flag is the carry out of bit 31 of that sum. Overflow is set when both addends have the same sign and the result's sign differs from it.
- R3: In add mode, bit k of nibCarry is the carry out of bits 4k+3..0 of the sum, for k = 0..7, so bit 7 always equals the carry flag.
- R4: In right-shift mode the result is opX shifted right arithmetically by shiftAmt (sign bits fill from the left). Overflow is 0, and carry is 1 when any 1 bit left through the low end.
- R5: In test mode the result equals opX and overflow is 0. Carry is 1 when any of the four bytes of opX is zero.
- R6: In left-shift mode the result is opX << shiftAmt. Carry is 1 when any discarded upper bit was 1. Overflow is 1 when any discarded bit differs from bit 31 of the result. A shift of 0 discards nothing.
- R7: In every mode other than add, nibCarry bit 7 equals the carry flag and bits 6..0 are 0.
- R8: flagsOut is {N, Z, V, C} in bits 3..0, in every mode. N is bit 31 of the result, and Z is 1 exactly when the result is 0.
- R9: With flagsIn = {N, Z, V, C}, selectors 0..7 give, in order: false, ~N, ~Z, ~V, ~C, ~(N^V), ~((N|Z)^V), C&~Z.
- R10: Selector 8+k gives the complement of selector k, for k = 0..7.
- R11: nibCarrySpread bit 4k equals nibCarry bit k, and every other bit of nibCarrySpread is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opX | input | 32 | First operand; shifted or tested operand |
| opY | input | 32 | Second addend, used in add mode |
| shiftAmt | input | 5 | Shift distance, 0 to 31 |
| mode | input | 2 | Flag mode select |
| condSel | input | 4 | Branch condition selector |
| flagsIn | input | 4 | Stored flags {N, Z, V, C} |
| result | output | 32 | Computed value |
| flagsOut | output | 4 | New flags {N, Z, V, C} |
| nibCarry | output | 8 | Per-nibble carry field |
| nibCarrySpread | output | 32 | Carry field, one bit per nibble at its low bit |
| condTrue | output | 1 | Selected condition holds |

## Verification
The block has no state, so any fault shows at the ports in the same cycle as the inputs that expose it. A broken link in the nibble carry chain shows as a wrong sum or a wrong nibCarry bit only when a carry must cross that nibble. For this reason the operand sweep includes all-ones values, values next to the sign boundary and every shift distance. A wrong shift mask shows only at particular distances, either as a lost carry on a right shift or as a missed overflow on a left shift. The condition path is covered by every selector against every flag pattern.

// File: rtl/flag_unit_pkg.sv
package flag_unit_pkg;

  typedef enum logic [1:0] {
    MODE_ADD  = 2'd0,
    MODE_SHR  = 2'd1,
    MODE_TEST = 2'd2,
    MODE_SHL  = 2'd3
  } flagMode_e;

  // strobes from control to datapath, one-hot over the four value sources
  typedef struct packed {
    logic selAdd;
    logic selShr;
    logic selTest;
    logic selShl;
    logic clearOvf;
  } flagStrobe_t;

endpackage

// File: rtl/flag_control.sv
module flag_control
  import flag_unit_pkg::*;
(
  input  logic [1:0]  mode,
  output flagStrobe_t strobe
);

  flagMode_e modeSel;

  always_comb begin
    modeSel = flagMode_e'(mode);
    strobe  = '0;
    case (modeSel)
      MODE_ADD:  strobe.selAdd  = 1'b1;
      MODE_SHR:  begin strobe.selShr  = 1'b1; strobe.clearOvf = 1'b1; end
      MODE_TEST: begin strobe.selTest = 1'b1; strobe.clearOvf = 1'b1; end
      default:   strobe.selShl  = 1'b1;
    endcase
  end

endmodule

// File: rtl/flag_datapath.sv
module flag_datapath
  import flag_unit_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int SHW   = 5
) (
  input  logic [WIDTH-1:0]   opX,
  input  logic [WIDTH-1:0]   opY,
  input  logic [SHW-1:0]     shiftAmt,
  input  flagStrobe_t        strobe,
  output logic [WIDTH-1:0]   result,
  output logic [3:0]         flagsOut,
  output logic [WIDTH/4-1:0] nibCarry,
  output logic [WIDTH-1:0]   nibCarrySpread
);

  localparam int NIBS  = WIDTH / 4;
  localparam int BYTES = WIDTH / 8;

  // add path: nibble-wise ripple so each nibble carry is visible
  logic [WIDTH-1:0] addend;
  logic [WIDTH-1:0] sumVal;
  logic [NIBS:0]    chain;
  logic             addOvf;

  assign addend   = opY << shiftAmt;
  assign chain[0] = 1'b0;

  for (genvar g = 0; g < NIBS; g++) begin : g_nib
    assign {chain[g+1], sumVal[4*g +: 4]} =
      {1'b0, opX[4*g +: 4]} + {1'b0, addend[4*g +: 4]} + {4'b0, chain[g]};
  end

  assign addOvf = (opX[WIDTH-1] == addend[WIDTH-1]) &&
                  (sumVal[WIDTH-1] != opX[WIDTH-1]);

  // shift paths
  logic [WIDTH-1:0]   lowMask;
  logic [WIDTH-1:0]   shrVal;
  logic               shrLost;
  logic [2*WIDTH-1:0] wideShl;
  logic [WIDTH-1:0]   shlVal;
  logic [WIDTH-1:0]   shlGone;
  logic [WIDTH-1:0]   signRep;
  logic               shlCarry;
  logic               shlOvf;

  assign lowMask  = ~({WIDTH{1'b1}} << shiftAmt);
  assign shrVal   = WIDTH'($signed(opX) >>> shiftAmt);
  assign shrLost  = |(opX & lowMask);
  assign wideShl  = {{WIDTH{1'b0}}, opX} << shiftAmt;
  assign shlVal   = wideShl[WIDTH-1:0];
  assign shlGone  = wideShl[2*WIDTH-1:WIDTH];
  assign signRep  = {WIDTH{shlVal[WIDTH-1]}} & lowMask;
  assign shlCarry = |shlGone;
  assign shlOvf   = (shlGone != signRep);

  // test path: zero byte detect
  logic [BYTES-1:0] byteZero;
  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign byteZero[b] = (opX[8*b +: 8] == 8'h00);
  end

  // source select
  logic carryOut;
  logic ovfOut;

  always_comb begin
    result   = opX;
    carryOut = 1'b0;
    ovfOut   = 1'b0;
    if (strobe.selAdd) begin
      result   = sumVal;
      carryOut = chain[NIBS];
      ovfOut   = addOvf;
    end else if (strobe.selShr) begin
      result   = shrVal;
      carryOut = shrLost;
    end else if (strobe.selTest) begin
      result   = opX;
      carryOut = |byteZero;
    end else if (strobe.selShl) begin
      result   = shlVal;
      carryOut = shlCarry;
      ovfOut   = shlOvf;
    end
    if (strobe.clearOvf) ovfOut = 1'b0;
  end

  assign flagsOut = {result[WIDTH-1], (result == '0), ovfOut, carryOut};
  assign nibCarry = strobe.selAdd ? chain[NIBS:1] : {carryOut, {(NIBS-1){1'b0}}};

  for (genvar g = 0; g < NIBS; g++) begin : g_spread
    assign nibCarrySpread[4*g +: 4] = {3'b000, nibCarry[g]};
  end

endmodule

// File: rtl/cond_eval.sv
module cond_eval (
  input  logic [3:0] flagsIn,
  input  logic [3:0] condSel,
  output logic       condTrue
);

  logic nFlag, zFlag, vFlag, cFlag;
  logic baseTest;

  assign {nFlag, zFlag, vFlag, cFlag} = flagsIn;

  always_comb begin
    case (condSel[2:0])
      3'd0:    baseTest = 1'b0;
      3'd1:    baseTest = ~nFlag;
      3'd2:    baseTest = ~zFlag;
      3'd3:    baseTest = ~vFlag;
      3'd4:    baseTest = ~cFlag;
      3'd5:    baseTest = ~(nFlag ^ vFlag);
      3'd6:    baseTest = ~((nFlag | zFlag) ^ vFlag);
      default: baseTest = cFlag & ~zFlag;
    endcase
  end

  // upper selector half inverts the lower half
  assign condTrue = baseTest ^ condSel[3];

endmodule

// File: rtl/flag_unit.sv
module flag_unit
  import flag_unit_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int SHW  = $clog2(WIDTH),
  localparam int NIBS = WIDTH / 4
) (
  input  logic [WIDTH-1:0] opX,
  input  logic [WIDTH-1:0] opY,
  input  logic [SHW-1:0]   shiftAmt,
  input  logic [1:0]       mode,
  input  logic [3:0]       condSel,
  input  logic [3:0]       flagsIn,
  output logic [WIDTH-1:0] result,
  output logic [3:0]       flagsOut,
  output logic [NIBS-1:0]  nibCarry,
  output logic [WIDTH-1:0] nibCarrySpread,
  output logic             condTrue
);

  flagStrobe_t strobe;

  flag_control i_control (
    .mode   (mode),
    .strobe (strobe)
  );

  flag_datapath #(.WIDTH(WIDTH), .SHW(SHW)) i_datapath (
    .opX            (opX),
    .opY            (opY),
    .shiftAmt       (shiftAmt),
    .strobe         (strobe),
    .result         (result),
    .flagsOut       (flagsOut),
    .nibCarry       (nibCarry),
    .nibCarrySpread (nibCarrySpread)
  );

  cond_eval i_cond (
    .flagsIn  (flagsIn),
    .condSel  (condSel),
    .condTrue (condTrue)
  );

endmodule

// File: rtl/flag_unit_chk.sv
module flag_unit_chk #(
  parameter int WIDTH = 32,
  localparam int NIBS = WIDTH / 4
) (
  input logic [WIDTH-1:0] opX,
  input logic [1:0]       mode,
  input logic [WIDTH-1:0] result,
  input logic [3:0]       flagsOut,
  input logic [NIBS-1:0]  nibCarry,
  input logic [WIDTH-1:0] nibCarrySpread
);

  always_comb begin
    // R8
    sign_flag_chk: assert (flagsOut[3] == result[WIDTH-1]);
    // R8
    zero_flag_chk: assert (flagsOut[2] == (result == '0));
    // R3
    top_carry_chk: assert (nibCarry[NIBS-1] == flagsOut[0]);
    if (mode == 2'd1 || mode == 2'd2) begin
      // R4
      ovf_clear_chk: assert (flagsOut[1] == 1'b0);
    end
    if (mode == 2'd2) begin
      // R5
      test_pass_chk: assert (result == opX);
    end
    if (mode != 2'd0) begin
      // R7
      carry_field_chk: assert (nibCarry[NIBS-2:0] == '0);
    end
  end

  for (genvar g = 0; g < NIBS; g++) begin : g_spread
    always_comb begin
      // R11
      spread_layout_chk: assert (nibCarrySpread[4*g +: 4] == {3'b000, nibCarry[g]});
    end
  end

endmodule

bind flag_unit flag_unit_chk #(.WIDTH(WIDTH)) i_flag_unit_chk (
  .opX            (opX),
  .mode           (mode),
  .result         (result),
  .flagsOut       (flagsOut),
  .nibCarry       (nibCarry),
  .nibCarrySpread (nibCarrySpread)
);

// File: tb/test_flag_unit.sv
module test_flag_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opX = '0, opY = '0;
  logic [4:0]  shiftAmt = '0;
  logic [1:0]  mode = '0;
  logic [3:0]  condSel = '0, flagsIn = '0;
  logic [31:0] result, nibCarrySpread;
  logic [3:0]  flagsOut;
  logic [7:0]  nibCarry;
  logic        condTrue;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2ns clk = ~clk;

  flag_unit i_flag_unit (
    .opX(opX), .opY(opY), .shiftAmt(shiftAmt), .mode(mode),
    .condSel(condSel), .flagsIn(flagsIn), .result(result),
    .flagsOut(flagsOut), .nibCarry(nibCarry),
    .nibCarrySpread(nibCarrySpread), .condTrue(condTrue)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h (x=%h y=%h s=%0d m=%0d sel=%h f=%h)",
               tag, act, exp, opX, opY, shiftAmt, mode, condSel, flagsIn);
    end
  endtask

  task automatic run_vec(logic [31:0] x, logic [31:0] y, logic [4:0] s, logic [1:0] m);
    logic [31:0] ys, z, gone, sMask, spread;
    logic [32:0] sum33;
    logic [63:0] wide, nibMask, part;
    logic        n, zf, v, c;
    logic [7:0]  field;
    string tagRes, tagFlg;
    @(posedge clk);
    opX = x; opY = y; shiftAmt = s; mode = m;
    sMask = (s == 0) ? 32'h0 : (32'hFFFF_FFFF >> (32 - s));
    v = 1'b0; c = 1'b0; field = '0; z = x;
    case (m)
      2'd0: begin
        ys = y << s;
        sum33 = {1'b0, x} + {1'b0, ys};
        z = sum33[31:0];
        c = sum33[32];
        v = (x[31] == ys[31]) && (z[31] != x[31]);
        for (int k = 0; k < 8; k++) begin
          nibMask = (64'd1 << (4*k+4)) - 64'd1;
          part = ({32'd0, x} & nibMask) + ({32'd0, ys} & nibMask);
          field[k] = part[4*k+4];
        end
        tagRes = "R1"; tagFlg = "R2";
      end
      2'd1: begin
        z = 32'($signed(x) >>> s);
        c = (x & sMask) != 0;
        tagRes = "R4"; tagFlg = "R4";
      end
      2'd2: begin
        c = (x[7:0] == 0) || (x[15:8] == 0) || (x[23:16] == 0) || (x[31:24] == 0);
        tagRes = "R5"; tagFlg = "R5";
      end
      default: begin
        wide = {32'd0, x} << s;
        z = wide[31:0];
        gone = wide[63:32];
        c = gone != 0;
        v = gone != (z[31] ? sMask : 32'h0);
        tagRes = "R6"; tagFlg = "R6";
      end
    endcase
    if (m != 2'd0) field = {c, 7'b0};
    n = z[31];
    zf = (z == 0);
    spread = '0;
    for (int k = 0; k < 8; k++) spread[4*k] = field[k];
    @(negedge clk);
    chk(tagRes, result, z);
    chk(tagFlg, {28'd0, flagsOut[1:0]}, {30'd0, v, c});
    chk("R8", {28'd0, flagsOut[3:2]}, {30'd0, n, zf});
    chk((m == 2'd0) ? "R3" : "R7", {24'd0, nibCarry}, {24'd0, field});
    chk("R11", nibCarrySpread, spread);
  endtask

  task automatic run_cond(logic [3:0] sel, logic [3:0] f);
    logic base, exp;
    @(posedge clk);
    condSel = sel; flagsIn = f;
    case (sel[2:0])
      3'd0: base = 0;
      3'd1: base = !f[3];
      3'd2: base = !f[2];
      3'd3: base = !f[1];
      3'd4: base = !f[0];
      3'd5: base = f[3] == f[1];
      3'd6: base = (f[3] | f[2]) == f[1];
      default: base = f[0] & !f[2];
    endcase
    exp = sel[3] ? !base : base;
    @(negedge clk);
    chk(sel[3] ? "R10" : "R9", {31'd0, condTrue}, {31'd0, exp});
  endtask

  logic [31:0] edges [8] = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000,
                             32'hFFFF_FFFF, 32'h00FF_00FF, 32'h1234_5678, 32'hF000_0001};

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state: all-zero inputs, add mode
    chk("R1", result, 32'h0);
    chk("R8", {28'd0, flagsOut}, 32'h4);
    chk("R9", {31'd0, condTrue}, 32'h0);
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          for (int s = 0; s < 32; s++)
            run_vec(edges[i], edges[j], 5'(s), 2'(m));
    for (int r = 0; r < 4000; r++)
      run_vec($urandom, $urandom, 5'($urandom_range(0, 15)), 2'(r % 4));
    // nibble carry ripple right to the top
    run_vec(32'h0FFF_FFFF, 32'h0000_0001, 5'd0, 2'd0);
    chk("R3", {24'd0, nibCarry}, 32'h7F);
    for (int sel = 0; sel < 16; sel++)
      for (int f = 0; f < 16; f++)
        run_cond(4'(sel), 4'(f));
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #600us;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule